// File: doc/BRIEF.md
# Dual-Channel Hiccup Soft-Start Supervisor

This block brings up two linear regulators together behind one shared digital soft-start ramp. A system sequencer raises `en` once the main switching supply is in regulation in its full-power state. The supervisor then drives a ramp code, which is converted to the regulators' soft-start reference, from zero up to the final reference code. While the ramp runs, it compares a digitised feedback code from each regulator with the present ramp value. If either output trails the ramp by more than a fixed margin, the block treats this as a short circuit or a supply failure. It then shuts both drivers off, waits a short idle time and restarts the ramp from zero. This restart is the hiccup.

Feedback arrives as a stream of paired samples with a valid/ready handshake. The block applies no back-pressure of its own. `fb_ready` simply follows `en`, so every sample offered while the block is enabled is consumed in that cycle. Samples offered while `en` is low are refused and have no effect. Once the ramp has reached the final code and both channels have shown a sample within a small tolerance of it, the supervisor declares soft-start complete. From then on it ignores feedback entirely until `en` falls. Codes are unsigned with an LSB of about 1 mV, so by default the target is 800, the margin is 100 and the ramp takes about 1.5 ms at 250 MHz.

Top module: `lin_ss_supervisor`

## Requirements
- R1: While `rst_n` or `en` is low, and one cycle after `en` falls, `ramp_code`, `drv_en`, `ss_done`, `in_reg` and `restart_cnt` are all zero.
- R2: One cycle after `en` rises, `drv_en` is 1 and the ramp starts at 0. The ramp rises by exactly one code every STEP_CYCLES cycles and holds at TARGET, never above it.
- R3: `fb_ready` equals `en`. Feedback is evaluated only in cycles where `fb_valid` and `fb_ready` are both 1. A failing feedback value with `fb_valid` low causes no restart.
- R4: During the ramp, an accepted sample in which either channel satisfies `fb + MARGIN < ramp_code` causes a hiccup. A channel exactly MARGIN below the ramp does not.
- R5: On a hiccup, `drv_en` and `ramp_code` go to 0 and `in_reg` is cleared. They stay at zero for exactly IDLE_CYCLES cycles, after which `drv_en` returns to 1 and the ramp restarts from 0.
- R6: Bit n of `in_reg` (channel n, taken from `fb_code[n*CODE_W +: CODE_W]`) is set by an accepted, non-failing sample taken while the ramp equals TARGET and channel n's feedback is at least TARGET−REG_TOL. The bit stays set until a hiccup or until `en` falls.
- R7: When both `in_reg` bits are set, `ss_done` becomes 1 in the same cycle. The failure check is then disabled: no feedback causes a restart until `en` falls.
- R8: `restart_cnt` increments by one on each hiccup and saturates at 2^RC_W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable from sequencer; low holds the block in reset |
| fb_valid | input | 1 | Feedback sample pair valid |
| fb_ready | output | 1 | Feedback sample accepted (equals `en`) |
| fb_code | input | NCH*CODE_W | Feedback codes; channel n in bits n*CODE_W +: CODE_W |
| ramp_code | output | CODE_W | Shared soft-start reference code |
| drv_en | output | 1 | Both regulator drivers enabled |
| ss_done | output | 1 | Soft-start complete, check disabled |
| in_reg | output | NCH | Per-channel in-regulation flags |
| restart_cnt | output | RC_W | Saturating hiccup count |

## Verification
The bench builds the block with a 10-bit code, TARGET 40, MARGIN 8, REG_TOL 2, a ramp step every 3 cycles, a 5-cycle idle time and a 3-bit restart counter. A full ramp then takes about 120 cycles, and a persistent short produces a hiccup roughly every 30 cycles. With these values, counter saturation, repeated restarts and the exact one-code margin boundary can all be reached many times within a short run. Random lag, short and valid patterns are compared every cycle against a reference model built from the requirements.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_OFF  = 2'd0,
    SS_RAMP = 2'd1,
    SS_IDLE = 2'd2,
    SS_DONE = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
  parameter int CODE_W      = 12,
  parameter int TARGET      = 800,
  parameter int STEP_CYCLES = 469
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  output logic [CODE_W-1:0] ramp,
  output logic              at_top
);
  localparam int STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
  localparam logic [CODE_W-1:0] TOP_CODE  = CODE_W'(TARGET);

  logic [STEP_W-1:0] step_q;
  logic [CODE_W-1:0] ramp_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      step_q <= '0;
      ramp_q <= '0;
    end else if (run) begin
      if (step_q == STEP_LAST) begin
        step_q <= '0;
        if (ramp_q < TOP_CODE) ramp_q <= ramp_q + 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign ramp   = ramp_q;
  assign at_top = (ramp_q == TOP_CODE);

  assert_ramp_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_q <= TOP_CODE);
  assert_ramp_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (ramp_q == $past(ramp_q) || ramp_q == $past(ramp_q) + 1'b1));
endmodule

// File: rtl/ss_chan_check.sv
module ss_chan_check #(
  parameter int CODE_W  = 12,
  parameter int TARGET  = 800,
  parameter int MARGIN  = 100,
  parameter int REG_TOL = 10
) (
  input  logic [CODE_W-1:0] fb,
  input  logic [CODE_W-1:0] ramp,
  input  logic              ramp_top,
  output logic              lag_fail,
  output logic              at_goal
);
  localparam logic [CODE_W:0]   MARGIN_X = (CODE_W+1)'(MARGIN);
  localparam logic [CODE_W-1:0] GOAL_MIN = CODE_W'(TARGET - REG_TOL);

  logic [CODE_W:0] fb_plus;

  always_comb begin
    fb_plus  = {1'b0, fb} + MARGIN_X;
    lag_fail = (fb_plus < {1'b0, ramp});
    at_goal  = ramp_top && (fb >= GOAL_MIN);
  end
endmodule

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
  import ss_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int RC_W        = 8,
  parameter int IDLE_CYCLES = 2500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            sample,
  input  logic [NCH-1:0]  lag_fail,
  input  logic [NCH-1:0]  at_goal,
  output logic            ramp_clr,
  output logic            ramp_run,
  output logic            drv_en,
  output logic            ss_done,
  output logic [NCH-1:0]  in_reg,
  output logic [RC_W-1:0] restart_cnt
);
  localparam int IDLE_W = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYCLES - 1);
  localparam logic [RC_W-1:0]   RC_MAX    = {RC_W{1'b1}};

  ss_state_e         state_q;
  logic [IDLE_W-1:0] idle_q;
  logic [NCH-1:0]    reg_q;
  logic [NCH-1:0]    reg_nxt;
  logic [RC_W-1:0]   rc_q;
  logic              done_q;
  logic              hiccup;

  always_comb begin
    hiccup   = (state_q == SS_RAMP) && sample && (|lag_fail);
    reg_nxt  = reg_q | (sample ? at_goal : '0);
    ramp_clr = !en || (state_q == SS_OFF) || (state_q == SS_IDLE) || hiccup;
    ramp_run = (state_q == SS_RAMP) && !hiccup;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state_q <= SS_OFF;
      idle_q  <= '0;
      reg_q   <= '0;
      rc_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SS_OFF: state_q <= SS_RAMP;
        SS_RAMP: begin
          if (hiccup) begin
            state_q <= SS_IDLE;
            idle_q  <= '0;
            reg_q   <= '0;
            if (rc_q != RC_MAX) rc_q <= rc_q + 1'b1;
          end else begin
            reg_q <= reg_nxt;
            if (&reg_nxt) begin
              state_q <= SS_DONE;
              done_q  <= 1'b1;
            end
          end
        end
        SS_IDLE: begin
          if (idle_q == IDLE_LAST) state_q <= SS_RAMP;
          else                     idle_q  <= idle_q + 1'b1;
        end
        SS_DONE: state_q <= SS_DONE;
        default: state_q <= SS_OFF;
      endcase
    end
  end

  assign drv_en      = (state_q == SS_RAMP) || (state_q == SS_DONE);
  assign ss_done     = done_q;
  assign in_reg      = reg_q;
  assign restart_cnt = rc_q;

  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == SS_OFF && rc_q == '0 && reg_q == '0 && !done_q));
  assert_hiccup_drops_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == SS_RAMP && sample && |lag_fail) |=> (state_q == SS_IDLE && reg_q == '0));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == SS_DONE) |=> (state_q == SS_DONE && done_q));
  assert_restart_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> (rc_q >= $past(rc_q)));
  assert_done_needs_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (&reg_q));
endmodule

// File: rtl/lin_ss_supervisor.sv
module lin_ss_supervisor #(
  parameter int NCH         = 2,
  parameter int CODE_W      = 12,
  parameter int TARGET      = 800,
  parameter int MARGIN      = 100,
  parameter int REG_TOL     = 10,
  parameter int STEP_CYCLES = 469,
  parameter int IDLE_CYCLES = 2500,
  parameter int RC_W        = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  fb_valid,
  output logic                  fb_ready,
  input  logic [NCH*CODE_W-1:0] fb_code,
  output logic [CODE_W-1:0]     ramp_code,
  output logic                  drv_en,
  output logic                  ss_done,
  output logic [NCH-1:0]        in_reg,
  output logic [RC_W-1:0]       restart_cnt
);
  logic              ramp_clr;
  logic              ramp_run;
  logic              ramp_top;
  logic              sample;
  logic [NCH-1:0]    lag_fail;
  logic [NCH-1:0]    at_goal;

  assign fb_ready = en;
  assign sample   = fb_valid && en;

  ss_ramp_gen #(
    .CODE_W(CODE_W), .TARGET(TARGET), .STEP_CYCLES(STEP_CYCLES)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .run(ramp_run),
    .ramp(ramp_code), .at_top(ramp_top)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    ss_chan_check #(
      .CODE_W(CODE_W), .TARGET(TARGET), .MARGIN(MARGIN), .REG_TOL(REG_TOL)
    ) u_chk (
      .fb(fb_code[ch*CODE_W +: CODE_W]), .ramp(ramp_code), .ramp_top(ramp_top),
      .lag_fail(lag_fail[ch]), .at_goal(at_goal[ch])
    );
  end

  ss_seq_ctrl #(
    .NCH(NCH), .RC_W(RC_W), .IDLE_CYCLES(IDLE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .sample(sample),
    .lag_fail(lag_fail), .at_goal(at_goal),
    .ramp_clr(ramp_clr), .ramp_run(ramp_run), .drv_en(drv_en),
    .ss_done(ss_done), .in_reg(in_reg), .restart_cnt(restart_cnt)
  );

  assert_ready_tracks_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_ready == en);
  assert_no_drive_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drv_en && ramp_code == '0));
endmodule

// File: tb/lin_ss_supervisor_bench.sv
`timescale 1ns/1ps
module lin_ss_supervisor_bench;
  localparam int NCH = 2, CW = 10, TGT = 40, MRG = 8, TOL = 2;
  localparam int STEP = 3, IDLE = 5, RCW = 3;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fb_valid = 1'b0;
  logic fb_ready, drv_en, ss_done;
  logic [NCH*CW-1:0] fb_code = '0;
  logic [CW-1:0] ramp_code;
  logic [NCH-1:0] in_reg;
  logic [RCW-1:0] restart_cnt;

  int checks = 0, failures = 0;
  bit finished = 0;
  int lag [NCH];
  bit shorted [NCH];

  // reference model state: 0 off, 1 ramp, 2 idle, 3 done
  int m_st, m_ramp, m_step, m_idle, m_rc;
  bit m_done;
  logic [NCH-1:0] m_reg;

  always #2 clk = ~clk;

  lin_ss_supervisor #(
    .NCH(NCH), .CODE_W(CW), .TARGET(TGT), .MARGIN(MRG), .REG_TOL(TOL),
    .STEP_CYCLES(STEP), .IDLE_CYCLES(IDLE), .RC_W(RCW)
  ) u_lin_ss_supervisor (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_valid(fb_valid), .fb_ready(fb_ready),
    .fb_code(fb_code), .ramp_code(ramp_code), .drv_en(drv_en), .ss_done(ss_done),
    .in_reg(in_reg), .restart_cnt(restart_cnt)
  );

  function automatic bit lags_out(int fb, int ramp);
    return (fb + MRG) < ramp;
  endfunction

  function automatic bit near_goal(int fb, int ramp);
    return (ramp == TGT) && (fb >= TGT - TOL);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_st = 0; m_ramp = 0; m_step = 0; m_idle = 0; m_rc = 0; m_done = 0; m_reg = '0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_ramp = 0; m_step = 0; end
        1: begin
          bit bad;
          logic [NCH-1:0] nr;
          bad = 0;
          nr = m_reg;
          for (int c = 0; c < NCH; c++) begin
            int f;
            f = int'(fb_code[c*CW +: CW]);
            if (fb_valid && lags_out(f, m_ramp)) bad = 1;
            if (fb_valid && near_goal(f, m_ramp)) nr[c] = 1'b1;
          end
          if (bad) begin
            m_st = 2; m_ramp = 0; m_step = 0; m_idle = 0; m_reg = '0;
            if (m_rc < (1 << RCW) - 1) m_rc = m_rc + 1;
          end else begin
            m_reg = nr;
            if (&nr) begin m_st = 3; m_done = 1; end
            if (m_step == STEP - 1) begin
              m_step = 0;
              if (m_ramp < TGT) m_ramp = m_ramp + 1;
            end else m_step = m_step + 1;
          end
        end
        2: begin
          if (m_idle == IDLE - 1) m_st = 1;
          else m_idle = m_idle + 1;
        end
        default: m_st = 3;
      endcase
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R2", int'(ramp_code), m_ramp, "ramp_code");
    check("R5", int'(drv_en), int'(m_st == 1 || m_st == 3), "drv_en");
    check("R7", int'(ss_done), int'(m_done), "ss_done");
    check("R6", int'(in_reg), int'(m_reg), "in_reg");
    check("R8", int'(restart_cnt), m_rc, "restart_cnt");
    check("R3", int'(fb_ready), int'(en), "fb_ready");
    for (int c = 0; c < NCH; c++) begin
      int r;
      r = int'(ramp_code);
      fb_code[c*CW +: CW] = shorted[c] ? '0 : CW'((r > lag[c]) ? r - lag[c] : 0);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_ch(int l0, bit s0, int l1, bit s1);
    lag[0] = l0; shorted[0] = s0; lag[1] = l1; shorted[1] = s1;
  endtask

  task automatic check_off(string what);
    check("R1", int'(ramp_code), 0, {what, " ramp"});
    check("R1", int'(drv_en), 0, {what, " drv_en"});
    check("R1", int'(ss_done), 0, {what, " ss_done"});
    check("R1", int'(in_reg), 0, {what, " in_reg"});
    check("R1", int'(restart_cnt), 0, {what, " restart_cnt"});
  endtask

  initial begin
    int base, zeros;
    void'($urandom(32'd5209));
    set_ch(0, 0, 0, 0);
    run(3);
    check_off("reset");
    rst_n = 1'b1;
    run(2);
    check_off("en low");

    // R2 / R6 / R7: clean start reaches regulation
    en = 1'b1; fb_valid = 1'b1;
    step();
    check("R2", int'(drv_en), 1, "drv on after enable");
    check("R2", int'(ramp_code), 0, "ramp starts at zero");
    run(140);
    check("R7", int'(ss_done), 1, "done after clean ramp");
    check("R6", int'(in_reg), 3, "both in regulation");
    check("R2", int'(ramp_code), TGT, "ramp holds at target");

    // R7: short after done is ignored
    set_ch(0, 0, 0, 1);
    run(200);
    check("R7", int'(restart_cnt), 0, "no restart after done");
    check("R7", int'(ss_done), 1, "done held");

    // R1: drop enable
    en = 1'b0; run(1);
    check_off("en dropped");
    en = 1'b1;

    // R4: exact margin lag never fails
    set_ch(0, 0, MRG, 0);
    run(400);
    check("R4", int'(restart_cnt), 0, "lag equal to margin keeps running");
    check("R6", int'(in_reg), 1, "only channel 0 regulated");
    check("R7", int'(ss_done), 0, "not done with lagging channel");

    // R4: one more code fails
    set_ch(0, 0, MRG + 1, 0);
    run(60);
    check("R4", int'(restart_cnt > 0), 1, "lag beyond margin restarts");

    // R5: idle length
    while (drv_en) step();
    zeros = 0;
    while (!drv_en) begin zeros++; step(); end
    check("R5", zeros, IDLE, "idle cycles off");
    check("R5", int'(ramp_code), 0, "ramp restarts from zero");

    // R3: invalid samples ignored
    en = 1'b0; run(1); en = 1'b1;
    fb_valid = 1'b0;
    set_ch(0, 1, 0, 1);
    run(300);
    check("R3", int'(restart_cnt), 0, "invalid samples ignored");
    check("R3", int'(ramp_code), TGT, "ramp completes without samples");
    fb_valid = 1'b1;
    run(3);
    check("R3", int'(restart_cnt), 1, "valid failing sample restarts");

    // R8: saturation
    run(1000);
    check("R8", int'(restart_cnt), (1 << RCW) - 1, "counter saturates");

    // random episodes
    for (int e = 0; e < 40; e++) begin
      if ($urandom % 3 == 0) begin en = 1'b0; run(1 + $urandom % 3); en = 1'b1; end
      for (int c = 0; c < NCH; c++) begin
        case ($urandom % 5)
          0: begin lag[c] = MRG; shorted[c] = 0; end
          1: begin lag[c] = MRG + 1; shorted[c] = 0; end
          2: begin lag[c] = 0; shorted[c] = 1; end
          default: begin lag[c] = $urandom % (TOL + 1); shorted[c] = 0; end
        endcase
      end
      base = 150 + $urandom % 200;
      for (int i = 0; i < base; i++) begin
        fb_valid = ($urandom % 4) != 0;
        step();
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule